// File: doc/BRIEF.md
# Rewindable FIFO with Retransmit Setup

A single-clock first-in first-out buffer whose read side can be rewound on demand. A word is shown on the output port as soon as it is available. It is held in an output register, and `out_vld` high means the register holds a word. A read consumes that word. Each master reset (`rst_n`) or partial reset (`clr`) marks the start of a new recording. The first word written after that reset goes to storage slot zero.

A retransmit request needs three inputs in the same clock cycle: `rt_req` high, `rt_mode` high, and `rd_cs_n` low. The request moves the read position back to slot zero. It also forces `out_vld` low for a fixed setup window of `SETUP_CYC` cycles. After the window, the first recorded word is loaded into the output register, and `out_vld` going high marks the end of setup. Reads are only meaningful after that edge.

Replay is only possible while the recording still sits intact in storage. The block therefore refuses a retransmit once `DEPTH-1` or more words have been written since the last reset, and it reports the refusal on `rt_err`. `DEPTH` must be a power of two.

Top module: `rt_fifo`

## Requirements
- R1: While `rst_n` is low, and one cycle after `clr` is sampled high, `out_vld`, `full` and `rt_err` are all low.
- R2: Words leave in the order they were written. When `out_vld` is low and stored data exists, the next word appears one cycle later. A read is counted only when `rd_en` is high, `rd_cs_n` is low and `out_vld` is high.
- R3: `full` is high when `DEPTH` words are held between the storage and the read position. A write while `full` is high is discarded.
- R4: A retransmit starts only if `rt_req` is high, `rt_mode` is high and `rd_cs_n` is low at the same edge. Any other combination leaves the data flow unchanged.
- R5: After an accepted retransmit edge, `out_vld` is low for the next `SETUP_CYC` cycles. If at least one word was written since reset, `out_vld` is high again at the `SETUP_CYC+1`-th edge after the request.
- R6: After setup, the output gives the first word written since the last reset, then every later word in write order. This includes words written during setup.
- R7: Read strobes issued during setup have no effect on which words are later delivered.
- R8: A retransmit request made while setup is in progress is ignored, and the setup window is not restarted.
- R9: A request made when `DEPTH-1` or more words were written since reset is refused. `rt_err` is high for exactly the following cycle, and reading continues undisturbed.
- R10: A partial reset `clr` empties the buffer and restarts the recording. A later retransmit replays from the first word written after `clr`.
- R11: While `rd_cs_n` is high, `rd_en` consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous master reset, active low |
| clr | input | 1 | Synchronous partial reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| full | output | 1 | Buffer full |
| rd_en | input | 1 | Read strobe |
| rd_cs_n | input | 1 | Read-side select, active low |
| rd_data | output | DW | Output register contents |
| out_vld | output | 1 | Output register holds a word; low during retransmit setup |
| rt_req | input | 1 | Retransmit strobe |
| rt_mode | input | 1 | Retransmit mode select |
| rt_err | output | 1 | One-cycle pulse on a refused retransmit |

## Verification
The directed tests cover several cases. A first retransmit is issued after a partial read, with reads and a second request held active through the setup window. Requests are issued with one of their three enables missing. A replay follows a partial reset, to show the recording restarts there. A fill reaches full, and a request is then refused. A replay runs at exactly `DEPTH-2` writes, the largest count still accepted. A random phase then mixes writes, reads, selects, requests and partial resets. Every cycle is compared against a queue-based model. This separates faults in the rewind target, the setup length, the gating of reads and requests, and the write-limit threshold.

// File: rtl/rt_fifo.sv
module rt_fifo #(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int SETUP_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  input  logic          rd_cs_n,
  output logic [DW-1:0] rd_data,
  output logic          out_vld,
  input  logic          rt_req,
  input  logic          rt_mode,
  output logic          rt_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(SETUP_CYC + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp, wcnt;
  logic          busy;
  logic [CW-1:0] cnt;

  wire [AW:0] used     = wp - rp;
  assign full          = (used == (AW+1)'(DEPTH));
  wire        wr_go    = wr_en && !full;
  wire        rd_go    = rd_en && !rd_cs_n && out_vld;
  wire        rt_hit   = rt_req && rt_mode && !rd_cs_n && !busy;
  wire        too_many = (wcnt >= (AW+1)'(DEPTH - 1));
  wire        rt_go    = rt_hit && !too_many;
  wire        fetch    = !busy && (!out_vld || rd_go) && (rp != wp);

  always_ff @(posedge clk)
    if (wr_go) mem[wp[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; wcnt <= '0; busy <= 1'b0; cnt <= '0;
      out_vld <= 1'b0; rd_data <= '0; rt_err <= 1'b0;
    end else if (clr) begin
      wp <= '0; rp <= '0; wcnt <= '0; busy <= 1'b0; cnt <= '0;
      out_vld <= 1'b0; rd_data <= '0; rt_err <= 1'b0;
    end else begin
      rt_err <= rt_hit && too_many;
      if (wr_go) begin
        wp <= wp + 1'b1;
        if (wcnt != (AW+1)'(DEPTH)) wcnt <= wcnt + 1'b1;
      end
      if (rt_go) begin
        busy    <= 1'b1;
        cnt     <= CW'(SETUP_CYC - 1);
        rp      <= '0;
        out_vld <= 1'b0;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end else if (fetch) begin
        rd_data <= mem[rp[AW-1:0]];
        rp      <= rp + 1'b1;
        out_vld <= 1'b1;
      end else if (rd_go) begin
        out_vld <= 1'b0;
      end
    end
  end

  // R5
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_go && !clr |=> busy && !out_vld && rp == '0);
  // R5
  setup_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_vld);
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 && !clr |=> busy && cnt == $past(cnt) - 1'b1);
  // R7
  hold_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !clr |=> rp == $past(rp));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !clr |=> wp == $past(wp));
  // R9
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_hit && too_many && !clr |=> rt_err && !busy);
endmodule

// File: tb/rt_fifo_test.sv
module rt_fifo_test;
  localparam int DW = 16, DEPTH = 16, SETUP_CYC = 3;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rd_cs_n = 1'b0, rt_req = 1'b0, rt_mode = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic full, out_vld, rt_err;
  logic [DW-1:0] rd_data;

  always #4 clk = ~clk;

  rt_fifo #(.DW(DW), .DEPTH(DEPTH), .SETUP_CYC(SETUP_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .rd_en(rd_en), .rd_cs_n(rd_cs_n), .rd_data(rd_data),
    .out_vld(out_vld), .rt_req(rt_req), .rt_mode(rt_mode), .rt_err(rt_err));

  int hist[$];
  int rp_m = 0, busy_m = 0, od_m = 0;
  bit ov_m = 0, err_m = 0;
  int nvec = 0, nbad = 0;
  bit done = 0;
  string cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      hist.delete(); rp_m = 0; busy_m = 0; od_m = 0; ov_m = 0; err_m = 0;
    end else begin
      bit trig, rej, fire, wrote;
      trig  = rt_req && rt_mode && !rd_cs_n && busy_m == 0;
      rej   = trig && hist.size() >= DEPTH - 1;
      fire  = rd_en && !rd_cs_n && ov_m;
      wrote = wr_en && (hist.size() - rp_m != DEPTH);
      err_m = rej;
      if (trig && !rej) begin
        busy_m = SETUP_CYC; rp_m = 0; ov_m = 0;
      end else if (busy_m > 0) begin
        busy_m--;
      end else if ((!ov_m || fire) && rp_m < hist.size()) begin
        od_m = hist[rp_m]; rp_m++; ov_m = 1;
      end else if (fire) begin
        ov_m = 0;
      end
      if (wrote) hist.push_back(int'(wr_data));
    end
  end

  task automatic cmp();
    bit full_m;
    full_m = (hist.size() - rp_m == DEPTH);
    nvec++;
    if (out_vld !== ov_m) begin
      nbad++; $display("FAIL %s out_vld got %0b exp %0b", cur_req, out_vld, ov_m);
    end
    nvec++;
    if (full !== full_m) begin
      nbad++; $display("FAIL %s full got %0b exp %0b", cur_req, full, full_m);
    end
    nvec++;
    if (rt_err !== err_m) begin
      nbad++; $display("FAIL %s rt_err got %0b exp %0b", cur_req, rt_err, err_m);
    end
    if (ov_m) begin
      nvec++;
      if (int'(rd_data) != od_m) begin
        nbad++; $display("FAIL %s rd_data got %0d exp %0d", cur_req, rd_data, od_m);
      end
    end
  endtask

  task automatic step(input bit w, input int d, input bit r, input bit cs_n,
                      input bit rq, input bit md, input bit c);
    @(negedge clk);
    cmp();
    wr_en = w; wr_data = DW'(d); rd_en = r; rd_cs_n = cs_n;
    rt_req = rq; rt_mode = md; clr = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    cmp();
    rst_n = 1'b1;
    idle(2);

    // R2: plain ordering with gaps
    cur_req = "R2";
    for (int i = 1; i <= 6; i++) step(1, 100 + i, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    idle(1);
    drain(2);
    idle(2);

    // R5 R6 R7 R8: retransmit, reads and second request during setup
    cur_req = "R5";
    step(0, 0, 0, 0, 1, 1, 0);
    cur_req = "R7";
    step(1, 107, 1, 0, 0, 0, 0);
    cur_req = "R8";
    step(0, 0, 1, 0, 1, 1, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    cur_req = "R6";
    idle(2);
    drain(9);
    idle(2);

    // R4: incomplete requests
    cur_req = "R4";
    step(1, 200, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    idle(3);

    // R11: deselected reads
    cur_req = "R11";
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0, 0, 0);
    drain(2);

    // R10: partial reset restarts recording
    cur_req = "R10";
    step(0, 0, 0, 0, 0, 0, 1);
    cur_req = "R1";
    step(0, 0, 0, 0, 0, 0, 0);
    cur_req = "R10";
    for (int i = 1; i <= 5; i++) step(1, 300 + i, 0, 0, 0, 0, 0);
    drain(3);
    step(0, 0, 0, 0, 1, 1, 0);
    idle(5);
    drain(7);

    // R3: fill to full, extra write dropped
    cur_req = "R3";
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 3; i++) step(1, 400 + i, 0, 0, 0, 0, 0);
    idle(2);
    // R9: too many writes, refused
    cur_req = "R9";
    step(0, 0, 0, 0, 1, 1, 0);
    idle(3);
    drain(DEPTH + 3);

    // R9 boundary: DEPTH-2 writes still accepted
    cur_req = "R9";
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH - 2; i++) step(1, 500 + i, 0, 0, 0, 0, 0);
    drain(4);
    step(0, 0, 0, 0, 1, 1, 0);
    idle(5);
    drain(DEPTH);

    // mixed random traffic, R2 R5 R6 R10
    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      bit w, r, cs, rq, c;
      w  = ($urandom % 2 == 0) && hist.size() < DEPTH - 2;
      r  = $urandom % 3 != 0;
      cs = $urandom % 8 == 0;
      rq = $urandom % 25 == 0;
      c  = $urandom % 90 == 0;
      step(w, $urandom % 60000, r, cs, rq, 1, c);
    end
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nbad++;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule